// File: doc/BRIEF.md
# Hook Switch and Dial Lock Supervisor

This block sits between the raw telephone-line controls and the dialer core. It filters the hook switch into a clean chip-enable. It filters each key contact on both press and release, and decides whether a filtered key press may reach the dialer. While the dial-pulse line is held during the off-hook delay, the block drives that line itself. It is clocked by the system clock and advances all of its timing on a one-cycle `tick_1ms` strobe. Every duration below is therefore a count of ticks.

A two-bit lock select describes how the three-state lock pin was wired. When that pin is tied high, the digits 0 and 9 are barred. When it is tied low, only 0 is barred. When it floats, dialing is unrestricted. Any barring setting puts the block in lock mode. Lock mode does three things:
- it shortens the hook filter;
- it adds a dial-line hold after every off-hook, with a distinct pattern on the first off-hook after power-up;
- it locks out the whole keypad when the first key of a call is a barred digit.

Going on-hook ends the call and clears the lockout.

Top module: `hook_lock_supervisor`

## Requirements
- R1: After synchronous reset `chip_en`, `dl_force`, `dl_level` and `key_valid` are 0 and the filtered hook state is on-hook.
- R2: With lock select floating (`lock_sel_hi`=0, `lock_sel_lo`=0), a hook level change is adopted only after 150 consecutive ticks of the new raw level, in both directions. `chip_en` is 1 exactly when the adopted state is off-hook (`hook_raw`=0), and a shorter excursion leaves it unchanged.
- R3: In lock mode (`lock_sel_hi` or `lock_sel_lo` set) the hook filter length is 20 ticks in both directions.
- R4: In lock mode every off-hook starts a 300-tick hold, beginning the cycle after `chip_en` rises. During the hold `dl_force`=1 and `dl_level`=0, except on the first off-hook described in R5. The hold is not applied when lock select is floating.
- R5: On the first adopted off-hook after reset, in lock mode, `dl_level` is 1 for the first 100 ticks of the hold and 0 for the remaining 200. That first off-hook consumes the first-off-hook flag whatever the lock mode is.
- R6: A filtered key press that occurs while the hold is active is rejected, and `key_valid` stays 0 for it.
- R7: Key codes 0 to 9 are the digits. With `lock_sel_hi`=1 the codes 0 and 9 are barred. With only `lock_sel_lo`=1 only code 0 is barred. With both 0 no code is barred.
- R8: If the first evaluated key of a call is barred, it is rejected and every later key is rejected until the next adopted on-hook or reset.
- R9: Barring applies only to the first evaluated key of a call; later barred digits are accepted.
- R10: Key contacts are filtered for 20 ticks on press and 20 ticks on release. An accepted press gives a one-cycle `key_valid` pulse with the code on `key_out`, and presses while `chip_en`=0 are rejected.
- R11: An adopted on-hook ends any running hold (`dl_force` returns to 0) and clears the lockout for the next call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_1ms | input | 1 | One-cycle timing strobe, one per millisecond |
| hook_raw | input | 1 | Raw hook switch, 1 = on-hook |
| lock_sel_hi | input | 1 | Lock pin tied high: bar 0 and 9 |
| lock_sel_lo | input | 1 | Lock pin tied low: bar 0 |
| key_down | input | 1 | Raw key contact present |
| key_code | input | 4 | Code of the key in contact |
| chip_en | output | 1 | Filtered off-hook, dialer enable |
| key_valid | output | 1 | One-cycle pulse for an accepted key |
| key_out | output | 4 | Code of the accepted key |
| dl_force | output | 1 | Dial-pulse line is driven by this block |
| dl_level | output | 1 | Level driven on the dial-pulse line while forced |

## Verification
The hardest situation to reach is the first-off-hook pattern, because it happens once per reset. To exercise it, the stimulus selects lock mode before the first off-hook. A later call in the same run then shows the plain all-low hold. Lockout is reached by making the very first filtered key of a call a barred digit, after the hold has ended. The stimulus also drops on-hook partway through a hold and re-enters with an allowed key, which shows that the abort and the lockout clear both work. A behavioural model in the bench counts ticks per call and is compared with every output on every cycle. Directed counts of accepted keys confirm each scenario.

// File: rtl/hls_pkg.sv
package hls_pkg;

    localparam int KEY_CODE_W = 4;
    typedef logic [KEY_CODE_W-1:0] key_code_t;

    localparam key_code_t DIGIT_ZERO = key_code_t'(0);
    localparam key_code_t DIGIT_NINE = key_code_t'(9);

    typedef enum logic [1:0] {
        LOCK_NONE      = 2'd0,
        LOCK_ZERO      = 2'd1,
        LOCK_ZERO_NINE = 2'd2
    } lock_mode_e;

    typedef struct packed {
        logic      valid;
        key_code_t code;
    } key_evt_t;

    typedef struct packed {
        logic busy;
        logic pattern_first;
        logic first_pending;
    } hold_state_t;

    function automatic lock_mode_e decode_lock(input logic sel_hi, input logic sel_lo);
        if (sel_hi)      return LOCK_ZERO_NINE;
        else if (sel_lo) return LOCK_ZERO;
        else             return LOCK_NONE;
    endfunction

    function automatic logic digit_barred(input lock_mode_e mode, input key_code_t code);
        case (mode)
            LOCK_ZERO_NINE: return (code == DIGIT_ZERO) || (code == DIGIT_NINE);
            LOCK_ZERO:      return (code == DIGIT_ZERO);
            default:        return 1'b0;
        endcase
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hls_debounce.sv
module hls_debounce #(
    parameter int   CNT_W = 8,
    parameter logic INIT  = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             raw,
    input  logic [CNT_W-1:0] limit,
    output logic             level,
    output logic             changed
);
    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= INIT;
            run_cnt <= '0;
            changed <= 1'b0;
        end else begin
            changed <= 1'b0;
            if (tick) begin
                if (raw == level) begin
                    run_cnt <= '0;
                end else if (run_cnt >= limit - CNT_W'(1)) begin
                    level   <= raw;
                    run_cnt <= '0;
                    changed <= 1'b1;
                end else begin
                    run_cnt <= run_cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/hls_offhook_seq.sv
module hls_offhook_seq
    import hls_pkg::*;
#(
    parameter int HOLD_MS       = 300,
    parameter int FIRST_HIGH_MS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic lock_active,
    input  logic off_evt,
    input  logic on_evt,
    output logic busy,
    output logic level
);
    localparam int HW = $clog2(HOLD_MS + 1);

    hold_state_t      st;
    logic [HW-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.busy          <= 1'b0;
            st.pattern_first <= 1'b0;
            st.first_pending <= 1'b1;
            cnt              <= '0;
        end else if (on_evt) begin
            st.busy <= 1'b0;
            cnt     <= '0;
        end else if (off_evt) begin
            st.busy          <= lock_active;
            st.pattern_first <= st.first_pending & lock_active;
            st.first_pending <= 1'b0;
            cnt              <= '0;
        end else if (st.busy && tick) begin
            if (cnt == HW'(HOLD_MS - 1)) st.busy <= 1'b0;
            else                         cnt     <= cnt + HW'(1);
        end
    end

    assign busy  = st.busy;
    assign level = st.busy & st.pattern_first & (cnt < HW'(FIRST_HIGH_MS));
endmodule

// File: rtl/hls_key_gate.sv
module hls_key_gate
    import hls_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chip_en,
    input  logic       hold_busy,
    input  lock_mode_e mode,
    input  logic       off_evt,
    input  logic       on_evt,
    input  logic       press_evt,
    input  key_code_t  code,
    output key_evt_t   acc
);
    logic locked_out;
    logic first_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_out <= 1'b0;
            first_open <= 1'b0;
            acc        <= '0;
        end else begin
            acc.valid <= 1'b0;
            if (on_evt) begin
                locked_out <= 1'b0;
                first_open <= 1'b0;
            end else if (off_evt) begin
                locked_out <= 1'b0;
                first_open <= 1'b1;
            end else if (press_evt && chip_en && !hold_busy && !locked_out) begin
                first_open <= 1'b0;
                if (first_open && digit_barred(mode, code)) begin
                    locked_out <= 1'b1;
                end else begin
                    acc.valid <= 1'b1;
                    acc.code  <= code;
                end
            end
        end
    end
endmodule

// File: rtl/hook_lock_supervisor.sv
module hook_lock_supervisor
    import hls_pkg::*;
#(
    parameter int HOOK_DB_NORMAL_MS = 150,
    parameter int HOOK_DB_LOCK_MS   = 20,
    parameter int HOLD_MS           = 300,
    parameter int FIRST_HIGH_MS     = 100,
    parameter int KEY_DB_MS         = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_1ms,
    input  logic                  hook_raw,
    input  logic                  lock_sel_hi,
    input  logic                  lock_sel_lo,
    input  logic                  key_down,
    input  logic [KEY_CODE_W-1:0] key_code,
    output logic                  chip_en,
    output logic                  key_valid,
    output logic [KEY_CODE_W-1:0] key_out,
    output logic                  dl_force,
    output logic                  dl_level
);
    localparam int HOOK_MAX = max_int(HOOK_DB_NORMAL_MS, HOOK_DB_LOCK_MS);
    localparam int HOOK_W   = $clog2(HOOK_MAX + 1);
    localparam int KEY_W    = $clog2(KEY_DB_MS + 1);

    lock_mode_e mode;
    logic       lock_active;
    logic [HOOK_W-1:0] hook_limit;

    logic hook_level, hook_chg, off_evt, on_evt;
    logic key_level, key_chg, press_evt;
    logic hold_busy, hold_level;
    key_evt_t acc;

    assign mode        = decode_lock(lock_sel_hi, lock_sel_lo);
    assign lock_active = (mode != LOCK_NONE);
    assign hook_limit  = lock_active ? HOOK_W'(HOOK_DB_LOCK_MS) : HOOK_W'(HOOK_DB_NORMAL_MS);

    hls_debounce #(.CNT_W(HOOK_W), .INIT(1'b1)) u_hook_db (
        .clk(clk), .rst(rst), .tick(tick_1ms), .raw(hook_raw),
        .limit(hook_limit), .level(hook_level), .changed(hook_chg)
    );

    hls_debounce #(.CNT_W(KEY_W), .INIT(1'b0)) u_key_db (
        .clk(clk), .rst(rst), .tick(tick_1ms), .raw(key_down),
        .limit(KEY_W'(KEY_DB_MS)), .level(key_level), .changed(key_chg)
    );

    assign off_evt   = hook_chg & ~hook_level;
    assign on_evt    = hook_chg &  hook_level;
    assign press_evt = key_chg  &  key_level;
    assign chip_en   = ~hook_level;

    hls_offhook_seq #(.HOLD_MS(HOLD_MS), .FIRST_HIGH_MS(FIRST_HIGH_MS)) u_seq (
        .clk(clk), .rst(rst), .tick(tick_1ms), .lock_active(lock_active),
        .off_evt(off_evt), .on_evt(on_evt), .busy(hold_busy), .level(hold_level)
    );

    hls_key_gate u_gate (
        .clk(clk), .rst(rst), .chip_en(chip_en), .hold_busy(hold_busy),
        .mode(mode), .off_evt(off_evt), .on_evt(on_evt),
        .press_evt(press_evt), .code(key_code), .acc(acc)
    );

    assign key_valid = acc.valid;
    assign key_out   = acc.code;
    assign dl_force  = hold_busy;
    assign dl_level  = hold_level;
endmodule

// File: rtl/hls_checker.sv
module hls_checker (
    input logic clk,
    input logic rst,
    input logic tick_1ms,
    input logic chip_en,
    input logic dl_force,
    input logic dl_level,
    input logic key_valid
);
    // R1: outputs idle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!chip_en && !dl_force && !dl_level && !key_valid));

    // R2: filtered hook state only moves on a tick
    p_hook_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(chip_en) |-> $past(tick_1ms));

    // R11: adopted on-hook releases the dial line
    p_onhook_release_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_en) |=> !dl_force);

    // R5: the high phase only opens a hold, never appears inside one
    p_no_late_high_r5: assert property (@(posedge clk) disable iff (rst)
        (dl_force && $past(dl_force)) |-> !$rose(dl_level));

    // R10: accepted key is a single-cycle pulse
    p_key_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> !key_valid);

    // R10: keys accepted only while enabled
    p_key_enabled_r10: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> $past(chip_en));
endmodule

bind hook_lock_supervisor hls_checker u_hls_checker (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .chip_en(chip_en),
    .dl_force(dl_force), .dl_level(dl_level), .key_valid(key_valid)
);

// File: tb/hook_lock_supervisor_test.sv
module hook_lock_supervisor_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1ms = 1'b0;
    logic hook_raw = 1'b1;
    logic lock_sel_hi = 1'b0;
    logic lock_sel_lo = 1'b0;
    logic key_down = 1'b0;
    logic [3:0] key_code = 4'd0;
    logic chip_en, key_valid, dl_force, dl_level;
    logic [3:0] key_out;

    int checks = 0;
    int errors = 0;
    int accepted = 0;
    int last_code = -1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hook_lock_supervisor uut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .hook_raw(hook_raw),
        .lock_sel_hi(lock_sel_hi), .lock_sel_lo(lock_sel_lo),
        .key_down(key_down), .key_code(key_code), .chip_en(chip_en),
        .key_valid(key_valid), .key_out(key_out), .dl_force(dl_force),
        .dl_level(dl_level)
    );

    always @(negedge clk) begin
        if (rst) tick_1ms <= 1'b0;
        else     tick_1ms <= ~tick_1ms;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: tick counters per call
    int m_hook = 1, m_hrun = 0, m_hevt = 0;
    int m_key = 0, m_krun = 0, m_kevt = 0;
    int m_busy = 0, m_cnt = 0, m_pfirst = 0, m_first = 1;
    int m_pend = 0, m_lock = 0, m_kv = 0, m_kcode = 0;

    always @(posedge clk) begin
        int lim;
        bit lk, bar;
        int o_hook, o_busy;
        if (rst) begin
            m_hook = 1; m_hrun = 0; m_hevt = 0; m_key = 0; m_krun = 0; m_kevt = 0;
            m_busy = 0; m_cnt = 0; m_pfirst = 0; m_first = 1;
            m_pend = 0; m_lock = 0; m_kv = 0;
        end else begin
            lk = lock_sel_hi || lock_sel_lo;
            o_hook = m_hook;
            o_busy = m_busy;
            m_kv = 0;
            if (m_hevt != 0 && m_hook == 1) begin
                m_lock = 0; m_pend = 0;
            end else if (m_hevt != 0 && m_hook == 0) begin
                m_lock = 0; m_pend = 1;
            end else if (m_kevt != 0 && m_key == 1 && o_hook == 0 && o_busy == 0 && m_lock == 0) begin
                bar = (lock_sel_hi && (key_code == 0 || key_code == 9)) ||
                      (!lock_sel_hi && lock_sel_lo && key_code == 0);
                if (m_pend != 0 && bar) m_lock = 1;
                else begin m_kv = 1; m_kcode = int'(key_code); end
                m_pend = 0;
            end
            if (m_hevt != 0 && m_hook == 1) begin
                m_busy = 0; m_cnt = 0;
            end else if (m_hevt != 0 && m_hook == 0) begin
                m_busy = lk ? 1 : 0; m_cnt = 0;
                m_pfirst = (m_first != 0 && lk) ? 1 : 0; m_first = 0;
            end else if (m_busy != 0 && tick_1ms) begin
                if (m_cnt == 299) m_busy = 0;
                else m_cnt++;
            end
            m_hevt = 0; m_kevt = 0;
            if (tick_1ms) begin
                lim = lk ? 20 : 150;
                if (int'(hook_raw) != m_hook) begin
                    m_hrun++;
                    if (m_hrun >= lim) begin m_hook = int'(hook_raw); m_hrun = 0; m_hevt = 1; end
                end else m_hrun = 0;
                if (int'(key_down) != m_key) begin
                    m_krun++;
                    if (m_krun >= 20) begin m_key = int'(key_down); m_krun = 0; m_kevt = 1; end
                end else m_krun = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(chip_en == (m_hook == 0), "R2/R3 chip_en vs model", chip_en, m_hook == 0);
            chk(dl_force == (m_busy != 0), "R4 dl_force vs model", dl_force, m_busy != 0);
            chk(dl_level == (m_busy != 0 && m_pfirst != 0 && m_cnt < 100),
                "R5 dl_level vs model", dl_level, m_busy != 0 && m_pfirst != 0 && m_cnt < 100);
            chk(key_valid == (m_kv != 0), "R10 key_valid vs model", key_valid, m_kv != 0);
            if (key_valid && m_kv != 0)
                chk(int'(key_out) == m_kcode, "R10 key_out vs model", key_out, m_kcode);
            if (key_valid) begin accepted++; last_code = int'(key_out); end
        end
    end

    task automatic wait_ms(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic press(input int code);
        key_code = 4'(code);
        key_down = 1'b1;
        wait_ms(30);
        key_down = 1'b0;
        wait_ms(30);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!chip_en && !dl_force && !dl_level && !key_valid, "R1 reset idle", chip_en, 0);

        // A: first off-hook in lock mode (0 and 9 barred)
        lock_sel_hi = 1'b1;
        hook_raw = 1'b0;
        wait_ms(30);
        chk(chip_en, "R3 lock off-hook adopted after 20", chip_en, 1);
        chk(dl_force && dl_level, "R5 first hold starts high", dl_level, 1);
        press(5);
        wait_ms(60);
        chk(dl_force && !dl_level, "R5 first hold low phase", dl_level, 0);
        chk(accepted == 0, "R6 key during hold rejected", accepted, 0);
        wait_ms(200);
        chk(!dl_force, "R4 hold ended", dl_force, 0);
        press(9);
        press(5);
        chk(accepted == 0, "R8 barred first key locks keypad", accepted, 0);
        hook_raw = 1'b1;
        wait_ms(10);
        chk(chip_en, "R3 on-hook not yet adopted", chip_en, 1);
        wait_ms(15);
        chk(!chip_en, "R3 on-hook adopted", chip_en, 0);
        press(4);
        chk(accepted == 0, "R10 key while on-hook rejected", accepted, 0);

        // B: later call, plain hold
        hook_raw = 1'b0;
        wait_ms(30);
        chk(dl_force && !dl_level, "R4 later hold is low", dl_level, 0);
        wait_ms(300);
        press(5);
        chk(accepted == 1 && last_code == 5, "R11 lockout cleared, key accepted", last_code, 5);
        press(9);
        press(0);
        chk(accepted == 3 && last_code == 0, "R9 later barred digits accepted", accepted, 3);
        key_code = 4'd7; key_down = 1'b1; wait_ms(10); key_down = 1'b0; wait_ms(40);
        chk(accepted == 3, "R10 short key contact ignored", accepted, 3);
        hook_raw = 1'b1; wait_ms(30);

        // C: only 0 barred
        lock_sel_hi = 1'b0; lock_sel_lo = 1'b1;
        hook_raw = 1'b0; wait_ms(340);
        press(9);
        chk(accepted == 4 && last_code == 9, "R7 nine allowed when only zero barred", last_code, 9);
        hook_raw = 1'b1; wait_ms(30);
        hook_raw = 1'b0; wait_ms(340);
        press(0);
        press(3);
        chk(accepted == 4, "R8 zero first locks keypad", accepted, 4);
        hook_raw = 1'b1; wait_ms(30);
        hook_raw = 1'b0; wait_ms(100);
        chk(dl_force, "R11 hold running before abort", dl_force, 1);
        hook_raw = 1'b1; wait_ms(30);
        chk(!dl_force && !chip_en, "R11 on-hook aborts hold", dl_force, 0);
        hook_raw = 1'b0; wait_ms(340);
        press(3);
        chk(accepted == 5 && last_code == 3, "R11 new call accepts key", accepted, 5);
        hook_raw = 1'b1; wait_ms(30);

        // D: floating lock select
        lock_sel_lo = 1'b0;
        hook_raw = 1'b0; wait_ms(100);
        hook_raw = 1'b1; wait_ms(200);
        chk(!chip_en, "R2 short off-hook excursion ignored", chip_en, 0);
        hook_raw = 1'b0; wait_ms(140);
        chk(!chip_en, "R2 off-hook not adopted before 150", chip_en, 0);
        wait_ms(20);
        chk(chip_en && !dl_force, "R2 adopted, R4 no hold when floating", dl_force, 0);
        press(0);
        chk(accepted == 6 && last_code == 0, "R7 zero allowed when floating", last_code, 0);
        hook_raw = 1'b1; wait_ms(100);
        chk(chip_en, "R2 on-hook not adopted before 150", chip_en, 1);
        wait_ms(60);
        chk(!chip_en, "R2 on-hook adopted", chip_en, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule